// File: doc/BRIEF.md
# Open-Block-Aware Flash Read Reorder Queue

This block sits in front of one flash channel and holds up to sixteen pending page reads. Each read names a block, a page inside that block and a tag. Only a few blocks can be open at once, and a page can only be read from an open block. A read to a closed block must first open it, which is slow. The queue therefore sends reads that land in an open block ahead of reads that would force an activation.

The block keeps a four-entry table of open blocks with least-recently-used replacement. When a request is issued on the output handshake, the table is updated on that same clock edge. A request to a block that was not open comes out with `out_activate` set, and its block replaces the table entry that was used longest ago. Every time a request is issued past an older one, the older one's bypass count goes up. Once any entry has been bypassed 32 times, it wins the next issue.

Selection is driven by a three-state machine:
- `ST_EMPTY`: nothing is held.
- `ST_SERVE`: normal hit-first selection.
- `ST_AGED`: at least one entry has reached the bypass limit, and the oldest such entry is forced out.

The transitions are:
- fill: `ST_EMPTY` to `ST_SERVE`.
- drain: any state to `ST_EMPTY`.
- starve: `ST_SERVE` to `ST_AGED`.
- relief: `ST_AGED` to `ST_SERVE`.

The next state is computed from the queue contents for the next cycle, so the state always matches the stored entries.

Top module: `flash_read_reorder`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. The open-block table is empty, so the first request issued carries `out_activate` = 1.
- R2: A request is stored in every cycle where `in_valid` and `in_ready` are both 1. `in_ready` is 0 exactly when 16 requests are held, and a request offered then is dropped.
- R3: Outside the aging override, if any held request targets an open block, the oldest such request is issued with `out_activate` = 0.
- R4: Outside the aging override, if no held request targets an open block, the oldest held request is issued with `out_activate` = 1.
- R5: Issuing a request to a closed block installs that block in the 4-entry table at the handshake edge. Later requests to it are hits, and no block ever occupies two table entries.
- R6: An installation uses the lowest-numbered empty table entry if there is one. Otherwise it replaces the entry whose block was issued to longest ago; issuing a hit refreshes that block's recency.
- R7: Each issue adds one to the bypass count of every held request older than the issued one. A request whose count reaches 32 is issued before all others, the oldest first when several have reached it.
- R8: `out_valid` is 1 exactly when the queue is non-empty. `out_block`, `out_page` and `out_tag` equal the fields of the chosen request.
- R9: While `out_valid` is 1 and `out_ready` is 0, nothing is removed and the table does not change. With no new request accepted, the outputs hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming read request valid |
| in_ready | output | 1 | Queue can take a request |
| in_block | input | 12 | Block address of incoming read |
| in_page | input | 8 | Page address of incoming read |
| in_tag | input | 6 | Tag of incoming read |
| out_valid | output | 1 | A chosen request is offered |
| out_ready | input | 1 | Downstream takes the offered request |
| out_block | output | 12 | Block address of chosen read |
| out_page | output | 8 | Page address of chosen read |
| out_tag | output | 6 | Tag of chosen read |
| out_activate | output | 1 | Chosen read targets a closed block |

## Verification
The hardest situation to reach from the ports is the forced issue of a starved request. It needs one request to a closed block to sit behind a steady stream of hits for 32 issues. The bench first opens a block, then parks a miss at the head of the queue behind fifteen hits to that open block while the output is stalled. It then pushes a new hit on every cycle while issuing, and counts how many issues pass the parked request before it comes out. A long random sweep over six block addresses, with a bench-side model of the queue and the LRU table, covers eviction order and stalls.

// File: rtl/frq_pkg.sv
package frq_pkg;
    localparam int BLK_W  = 12;
    localparam int PAGE_W = 8;
    localparam int TAG_W  = 6;

    typedef struct packed {
        logic [BLK_W-1:0]  blk;
        logic [PAGE_W-1:0] page;
        logic [TAG_W-1:0]  tag;
    } rd_req_t;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_SERVE = 2'd1,
        ST_AGED  = 2'd2
    } frq_state_e;
endpackage

// File: rtl/frq_open_table.sv
module frq_open_table
    import frq_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BLK_W-1:0] probe_blk [DEPTH],
    output logic [DEPTH-1:0] probe_hit,
    input  logic             upd_en,
    input  logic [BLK_W-1:0] upd_blk
);
    localparam int RW = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam logic [RW-1:0] RANK_LRU = RW'(WAYS - 1);

    logic [BLK_W-1:0] way_blk  [WAYS];
    logic [WAYS-1:0]  way_v;
    logic [RW-1:0]    way_rank [WAYS];
    logic [WAYS-1:0]  upd_match;
    logic [RW-1:0]    tgt;

    function automatic logic blk_present(input logic [BLK_W-1:0] b);
        logic r;
        r = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_v[w] && way_blk[w] == b) r = 1'b1;
        end
        return r;
    endfunction

    always_comb begin
        for (int i = 0; i < DEPTH; i++) probe_hit[i] = blk_present(probe_blk[i]);
    end

    // target way: matching way, else lowest empty way, else LRU way
    always_comb begin
        logic found_inv;
        tgt = '0;
        found_inv = 1'b0;
        for (int w = 0; w < WAYS; w++) upd_match[w] = way_v[w] && way_blk[w] == upd_blk;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_rank[w] == RANK_LRU) tgt = RW'(w);
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_v[w]) begin
                tgt = RW'(w);
                found_inv = 1'b1;
            end
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (upd_match[w]) tgt = RW'(w);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            way_v <= '0;
            for (int w = 0; w < WAYS; w++) begin
                way_blk[w]  <= '0;
                way_rank[w] <= RW'(w);
            end
        end else if (upd_en) begin
            way_blk[tgt] <= upd_blk;
            way_v[tgt]   <= 1'b1;
            for (int w = 0; w < WAYS; w++) begin
                if (RW'(w) == tgt) way_rank[w] <= '0;
                else if (way_rank[w] < way_rank[tgt]) way_rank[w] <= way_rank[w] + 1'b1;
            end
        end
    end

    assert_unique_ways_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(upd_match) <= 1);

    assert_installed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> blk_present($past(upd_blk)));
endmodule

// File: rtl/frq_picker.sv
module frq_picker #(
    parameter int DEPTH     = 16,
    parameter int AGE_LIMIT = 32,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int AGE_W    = $clog2(AGE_LIMIT + 1)
) (
    input  logic [CNT_W-1:0] count,
    input  logic             force_mode,
    input  logic [DEPTH-1:0] hit,
    input  logic [AGE_W-1:0] age [DEPTH],
    output logic [IDX_W-1:0] sel
);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(AGE_LIMIT);

    always_comb begin
        logic [IDX_W-1:0] hit_idx;
        logic [IDX_W-1:0] aged_idx;
        logic             any_hit;
        hit_idx  = '0;
        aged_idx = '0;
        any_hit  = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (i < int'(count)) begin
                if (hit[i]) begin
                    hit_idx = IDX_W'(i);
                    any_hit = 1'b1;
                end
                if (age[i] >= AGE_MAX) aged_idx = IDX_W'(i);
            end
        end
        if (force_mode)   sel = aged_idx;
        else if (any_hit) sel = hit_idx;
        else              sel = '0;
    end
endmodule

// File: rtl/flash_read_reorder.sv
module flash_read_reorder
    import frq_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int WAYS      = 4,
    parameter int AGE_LIMIT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BLK_W-1:0]  in_block,
    input  logic [PAGE_W-1:0] in_page,
    input  logic [TAG_W-1:0]  in_tag,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BLK_W-1:0]  out_block,
    output logic [PAGE_W-1:0] out_page,
    output logic [TAG_W-1:0]  out_tag,
    output logic              out_activate
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int AGE_W = $clog2(AGE_LIMIT + 1);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(AGE_LIMIT);
    localparam logic [CNT_W-1:0] FULL    = CNT_W'(DEPTH);

    frq_state_e       state_q, state_d;
    rd_req_t          q_req [DEPTH];
    rd_req_t          req_d [DEPTH];
    logic [AGE_W-1:0] q_age [DEPTH];
    logic [AGE_W-1:0] age_d [DEPTH];
    logic [BLK_W-1:0] probe_blk [DEPTH];
    logic [DEPTH-1:0] hit_vec;
    logic [CNT_W-1:0] cnt, cnt_mid, cnt_d;
    logic [IDX_W-1:0] sel;
    logic             issue, push, aged_next, aged_now;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) probe_blk[i] = q_req[i].blk;
    end

    frq_open_table #(.WAYS(WAYS), .DEPTH(DEPTH)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .probe_blk (probe_blk),
        .probe_hit (hit_vec),
        .upd_en    (issue),
        .upd_blk   (out_block)
    );

    frq_picker #(.DEPTH(DEPTH), .AGE_LIMIT(AGE_LIMIT)) u_pick (
        .count      (cnt),
        .force_mode (state_q == ST_AGED),
        .hit        (hit_vec),
        .age        (q_age),
        .sel        (sel)
    );

    assign in_ready = (cnt != FULL);
    assign issue    = out_valid && out_ready;
    assign push     = in_valid && in_ready;

    // next contents: close the gap at sel, age older entries, append new request
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            int src;
            src = (issue && i >= int'(sel)) ? i + 1 : i;
            if (src < DEPTH) begin
                req_d[i] = q_req[src[IDX_W-1:0]];
                age_d[i] = q_age[src[IDX_W-1:0]];
            end else begin
                req_d[i] = '0;
                age_d[i] = '0;
            end
            if (issue && i < int'(sel) && q_age[i] < AGE_MAX) age_d[i] = q_age[i] + 1'b1;
        end
        cnt_mid = cnt - CNT_W'(issue);
        if (push) begin
            req_d[cnt_mid[IDX_W-1:0]] = '{blk: in_block, page: in_page, tag: in_tag};
            age_d[cnt_mid[IDX_W-1:0]] = '0;
        end
        cnt_d = cnt_mid + CNT_W'(push);
        aged_next = 1'b0;
        aged_now  = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (i < int'(cnt_d) && age_d[i] >= AGE_MAX) aged_next = 1'b1;
            if (i < int'(cnt) && q_age[i] >= AGE_MAX) aged_now = 1'b1;
        end
    end

    // next state: drain / fill / starve / relief
    always_comb begin
        unique case (state_q)
            ST_EMPTY: state_d = (cnt_d != 0) ? ST_SERVE : ST_EMPTY;
            ST_SERVE: state_d = (cnt_d == 0) ? ST_EMPTY : (aged_next ? ST_AGED : ST_SERVE);
            ST_AGED:  state_d = (cnt_d == 0) ? ST_EMPTY : (aged_next ? ST_AGED : ST_SERVE);
            default:  state_d = ST_EMPTY;
        endcase
    end

    // state register and storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            cnt     <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                q_req[i] <= '0;
                q_age[i] <= '0;
            end
        end else begin
            state_q <= state_d;
            cnt     <= cnt_d;
            for (int i = 0; i < DEPTH; i++) begin
                q_req[i] <= req_d[i];
                q_age[i] <= age_d[i];
            end
        end
    end

    // outputs
    always_comb begin
        out_valid    = 1'b0;
        out_block    = '0;
        out_page     = '0;
        out_tag      = '0;
        out_activate = 1'b0;
        unique case (state_q)
            ST_EMPTY: out_valid = 1'b0;
            ST_SERVE, ST_AGED: begin
                out_valid    = 1'b1;
                out_block    = q_req[sel].blk;
                out_page     = q_req[sel].page;
                out_tag      = q_req[sel].tag;
                out_activate = !hit_vec[sel];
            end
            default: out_valid = 1'b0;
        endcase
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL);

    assert_empty_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY) == (cnt == 0));

    assert_serve_unaged_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SERVE) |-> !aged_now);

    assert_forced_pick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_AGED) |-> (q_age[sel] == AGE_MAX));

    assert_hit_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SERVE && (hit_vec & ((DEPTH'(1) << cnt) - 1'b1)) != 0) |-> !out_activate);

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !push) |=>
            (out_valid && $stable(out_tag) && $stable(out_block) && $stable(out_activate)));
endmodule

// File: tb/test_flash_read_reorder.sv
`timescale 1ns/1ps
module test_flash_read_reorder;
    import frq_pkg::*;

    localparam int DEPTH = 16;
    localparam int WAYS  = 4;
    localparam int LIMIT = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, out_ready = 1'b0;
    logic in_ready, out_valid, out_activate;
    logic [BLK_W-1:0]  in_block = '0, out_block;
    logic [PAGE_W-1:0] in_page = '0, out_page;
    logic [TAG_W-1:0]  in_tag = '0, out_tag;

    always #2.5 clk = ~clk;

    flash_read_reorder #(.DEPTH(DEPTH), .WAYS(WAYS), .AGE_LIMIT(LIMIT)) i_flash_read_reorder (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_block(in_block), .in_page(in_page), .in_tag(in_tag),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_block(out_block), .out_page(out_page), .out_tag(out_tag),
        .out_activate(out_activate)
    );

    int n_cmp = 0, n_bad = 0;
    int m_blk [DEPTH], m_page [DEPTH], m_tag [DEPTH], m_age [DEPTH];
    int m_cnt = 0;
    int t_blk [WAYS], t_stamp [WAYS];
    bit t_v [WAYS];
    int stamp_now = 0;
    bit prev_stall = 0;
    int last_tag = -1, last_act = -1, n_issued = 0;

    task automatic check(string req, int act, int exp, string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int m_hit(int b);
        for (int w = 0; w < WAYS; w++) if (t_v[w] && t_blk[w] == b) return w;
        return -1;
    endfunction

    function automatic bit m_full_table();
        for (int w = 0; w < WAYS; w++) if (!t_v[w]) return 0;
        return 1;
    endfunction

    function automatic int m_pick(output bit forced);
        forced = 0;
        for (int i = 0; i < m_cnt; i++) if (m_age[i] >= LIMIT) begin forced = 1; return i; end
        for (int i = 0; i < m_cnt; i++) if (m_hit(m_blk[i]) >= 0) return i;
        return 0;
    endfunction

    task automatic m_touch(int b);
        int w;
        w = m_hit(b);
        if (w < 0) begin
            for (int j = WAYS - 1; j >= 0; j--) if (!t_v[j]) w = j;
            if (w < 0) begin
                w = 0;
                for (int j = 1; j < WAYS; j++) if (t_stamp[j] < t_stamp[w]) w = j;
            end
        end
        t_v[w] = 1;
        t_blk[w] = b;
        stamp_now++;
        t_stamp[w] = stamp_now;
    endtask

    // one clock: check outputs against the model, drive inputs, advance the model
    task automatic cycle(bit push, int b, int p, int t, bit rdy);
        int k;
        bit forced, exp_act, did_push;
        string lab;
        @(negedge clk);
        check("R8", int'(out_valid), int'(m_cnt > 0), "out_valid");
        check("R2", int'(in_ready), int'(m_cnt < DEPTH), "in_ready");
        k = 0;
        if (m_cnt > 0) begin
            k = m_pick(forced);
            exp_act = (m_hit(m_blk[k]) < 0);
            lab = prev_stall ? "R9" : (forced ? "R7" : (exp_act ? "R4" : "R3"));
            check(lab, int'(out_tag), m_tag[k], "out_tag");
            check("R8", int'(out_block), m_blk[k], "out_block");
            check("R8", int'(out_page), m_page[k], "out_page");
            check((exp_act && m_full_table()) ? "R6" : "R5", int'(out_activate), int'(exp_act), "out_activate");
            if (rdy) begin
                last_tag = int'(out_tag);
                last_act = int'(out_activate);
                n_issued++;
            end
        end
        in_valid  = push;
        in_block  = BLK_W'(b);
        in_page   = PAGE_W'(p);
        in_tag    = TAG_W'(t);
        out_ready = rdy;
        did_push  = push && (m_cnt < DEPTH);
        prev_stall = (m_cnt > 0) && !rdy;
        if (rdy && m_cnt > 0) begin
            m_touch(m_blk[k]);
            for (int i = 0; i < k; i++) if (m_age[i] < LIMIT) m_age[i]++;
            for (int i = k; i < m_cnt - 1; i++) begin
                m_blk[i] = m_blk[i+1]; m_page[i] = m_page[i+1];
                m_tag[i] = m_tag[i+1]; m_age[i] = m_age[i+1];
            end
            m_cnt--;
        end
        if (did_push) begin
            m_blk[m_cnt] = b; m_page[m_cnt] = p; m_tag[m_cnt] = t; m_age[m_cnt] = 0;
            m_cnt++;
        end
    endtask

    task automatic drain();
        while (m_cnt > 0) cycle(0, 0, 0, 0, 1);
        cycle(0, 0, 0, 0, 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        int seq_blk [8];
        int seq_act [8];
        int bypass;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and first issue needs activation
        @(negedge clk);
        check("R1", int'(out_valid), 0, "out_valid after reset");
        check("R1", int'(in_ready), 1, "in_ready after reset");
        cycle(1, 7, 1, 1, 0);
        cycle(0, 0, 0, 0, 1);
        check("R1", last_act, 1, "first issue activate");
        drain();

        // R2: fill past capacity while stalled (R9), then drain
        for (int i = 0; i < DEPTH + 1; i++) cycle(1, 40 + (i % 5), i, i, 0);
        check("R2", int'(m_cnt), DEPTH, "model count after overfill");
        @(negedge clk);
        check("R2", int'(in_ready), 0, "in_ready when full");
        drain();

        // R6: LRU replacement order, one request at a time
        seq_blk = '{21, 22, 23, 24, 21, 25, 22, 21};
        seq_act = '{1, 1, 1, 1, 0, 1, 1, 0};
        for (int i = 0; i < 8; i++) begin
            cycle(1, seq_blk[i], i, 50 + i, 0);
            cycle(0, 0, 0, 0, 1);
            check("R6", last_act, seq_act[i], "activate in LRU sequence");
        end
        drain();

        // R7: a miss parked behind a stream of hits to block 21
        cycle(1, 99, 3, 63, 0);
        for (int i = 0; i < DEPTH - 1; i++) cycle(1, 21, i, i, 0);
        bypass = 0;
        last_tag = -1;
        for (int i = 0; i < 60 && last_tag != 63; i++) begin
            cycle(1, 21, i, (i + 15) % 60, 1);
            if (last_tag != 63) bypass++;
        end
        check("R7", bypass, LIMIT, "issues passing the parked miss");
        check("R7", last_act, 1, "parked miss activate");
        drain();

        // sweep: random mix of blocks, stalls and pushes
        for (int i = 0; i < 4000; i++) begin
            cycle(($urandom % 4) != 0, $urandom % 6, $urandom % 256, i % 64, ($urandom % 10) < 6);
        end
        drain();

        summary();
        $finish;
    end
endmodule